// File: doc/BRIEF.md
# Indexed DMA Channel Sequencer

This block sequences the transfers of one DMA channel. It holds a source and a destination address and steps each of them after every element transfer. Ordinary transfers apply an element step, and the last transfer of each frame applies a frame step. It counts elements within a frame and frames within a block. It paces each element either freely or on the rising edge of one selected event line. It pulses an interrupt according to a small mode matrix. The bus read and write itself happens elsewhere: the sequencer raises `xfer_req` and waits for `xfer_done`.

Software programs the configuration inputs and pulses `start`. The configuration must stay unchanged while `active` is high. In ring (autobuffer) mode the frame count is ignored. The element count is then the buffer length, and the channel runs one buffer after another until reset. The controller states are `ST_IDLE` (channel off), `ST_WAIT_EV` (waiting for pacing) and `ST_REQ` (request raised, waiting for done). The transitions are:
- IDLE→WAIT_EV on `start`.
- WAIT_EV→REQ when free-running or when an event is pending.
- REQ→WAIT_EV on `xfer_done`, except on the final transfer of a block.
- REQ→IDLE on `xfer_done` for the final transfer of a block.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset `xfer_req`, `active`, `block_done`, `irq` and `overrun` are 0 and both addresses are 0.
- R2: A `start` pulse in idle loads both addresses from their start inputs and raises `active` in the next cycle. The first transfer uses the start addresses.
- R3: After each done that is not the last in its frame, each side steps by its 2-bit select: 00 hold, 01 +1, 10 -1, 11 add `elem_idx`. The index is 16-bit two's complement, and the sum wraps at the address width.
- R4: After the last done of a frame, select 11 adds `frame_idx` instead. This holds for single-frame and multi-frame blocks.
- R5: The element counter reloads from `elem_cnt` at each frame boundary. A block has `elem_cnt`×`frame_cnt` transfers. `block_done` pulses in the cycle of the final done, and `active` is 0 in the next cycle.
- R6: With `irq_en`=0, `irq` never rises.
- R7: Multi-frame, `irq_en`=1, `irq_sel`=0: `irq` pulses only with the final done of the block.
- R8: Multi-frame, `irq_en`=1, `irq_sel`=1: `irq` pulses with the last done of every frame.
- R9: Ring mode, `irq_en`=1, `irq_sel`=0: `irq` pulses with every `elem_cnt`-th done. The channel keeps running and `block_done` never rises.
- R10: Ring mode with `irq_sel`=1 also pulses `irq` with done number floor(`elem_cnt`/2) of each buffer.
- R11: `sync_code`=0000 runs free. `xfer_req` rises two cycles after `start` and again two cycles after each done.
- R12: The sync codes select event lines as follows: 0001→bit0, 0010→bit1, 0101→bit2, 0110→bit3, 1101→bit4, 1110→bit5, 1111→bit6. Each rising edge of the selected line allows exactly one transfer. Other lines, and all reserved codes, cause none.
- R13: An edge seen during a transfer is held pending. A further edge while one is pending sets `overrun`, which stays set until the next `start`.
- R14: `xfer_req` stays high, with both addresses unchanged, until `xfer_done`. `irq` only rises in a cycle with `xfer_done` and `xfer_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, honoured in idle |
| src_start | input | AW | Source start address |
| dst_start | input | AW | Destination start address |
| src_step | input | 2 | Source step select |
| dst_step | input | 2 | Destination step select |
| elem_idx | input | 16 | Element index (signed) |
| frame_idx | input | 16 | Frame index (signed) |
| elem_cnt | input | CW | Elements per frame / buffer length (≥1, ≥2 in ring mode) |
| frame_cnt | input | CW | Frames per block (≥1) |
| ring_mode | input | 1 | 1 = autobuffer ring, 0 = multi-frame |
| irq_en | input | 1 | Interrupt enable |
| irq_sel | input | 1 | Interrupt mode select |
| sync_code | input | 4 | Pacing event select |
| sync_ev | input | NEV | Event lines |
| xfer_done | input | 1 | Transfer complete handshake |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| xfer_req | output | 1 | Transfer request |
| active | output | 1 | Channel enabled |
| block_done | output | 1 | One-cycle block completion |
| irq | output | 1 | One-cycle interrupt |
| overrun | output | 1 | Sticky pacing overrun |

## Verification
The bench stresses the frame boundary. A design that applied the element step there, or forgot to reload the element counter, would produce wrong addresses from the second frame on. It runs each interrupt mode, where a swapped matrix entry shows up as a pulse at a frame end that should be quiet, or as a missing half-buffer pulse. It pulses event lines other than the selected one and uses a reserved code, where a wrong decode would launch stray transfers. It stacks three edges during one unanswered request, so a design without a pending latch would miss the overrun or flag it one edge early.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_EV = 2'd1,
        ST_REQ     = 2'd2
    } seq_state_t;

    localparam logic [1:0] STEP_HOLD = 2'b00;
    localparam logic [1:0] STEP_INC  = 2'b01;
    localparam logic [1:0] STEP_DEC  = 2'b10;
    localparam logic [1:0] STEP_IDX  = 2'b11;

    localparam int unsigned IDX_W     = 16;
    localparam logic [3:0]  SLOT_NONE = 4'hF;

    // Map a pacing code to an event-line slot; SLOT_NONE for free/reserved.
    function automatic logic [3:0] ev_slot(input logic [3:0] code);
        logic [3:0] slot;
        unique case (code)
            4'b0001: slot = 4'd0;
            4'b0010: slot = 4'd1;
            4'b0101: slot = 4'd2;
            4'b0110: slot = 4'd3;
            4'b1101: slot = 4'd4;
            4'b1110: slot = 4'd5;
            4'b1111: slot = 4'd6;
            default: slot = SLOT_NONE;
        endcase
        return slot;
    endfunction

endpackage

// File: rtl/dma_sync_sel.sv
module dma_sync_sel
    import dma_seq_pkg::*;
#(
    parameter int unsigned NEV = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [3:0]     code,
    input  logic [NEV-1:0] ev,
    input  logic           clr,
    input  logic           consume,
    output logic           pending,
    output logic           overrun
);
    localparam int unsigned SW = (NEV > 1) ? $clog2(NEV) : 1;

    logic [NEV-1:0] ev_q;
    logic [3:0]     slot;
    logic           sel_now;
    logic           sel_prev;
    logic           rise;

    always_comb begin
        slot     = ev_slot(code);
        sel_now  = 1'b0;
        sel_prev = 1'b0;
        if (32'(slot) < NEV) begin
            sel_now  = ev[SW'(slot)];
            sel_prev = ev_q[SW'(slot)];
        end
        rise = sel_now & ~sel_prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q    <= '0;
            pending <= 1'b0;
            overrun <= 1'b0;
        end else begin
            ev_q <= ev;
            if (clr) begin
                pending <= 1'b0;
                overrun <= 1'b0;
            end else begin
                if (rise && pending && !consume)
                    overrun <= 1'b1;
                pending <= rise | (pending & ~consume);
            end
        end
    end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_seq_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0]    cur,
    input  logic [1:0]       sel,
    input  logic [IDX_W-1:0] elem_idx,
    input  logic [IDX_W-1:0] frame_idx,
    input  logic             last,
    output logic [AW-1:0]    nxt
);
    logic [IDX_W-1:0] idx;
    logic [AW-1:0]    ext;

    always_comb begin
        idx = last ? frame_idx : elem_idx;
        ext = AW'($signed(idx));
        unique case (sel)
            STEP_HOLD: nxt = cur;
            STEP_INC:  nxt = cur + AW'(1);
            STEP_DEC:  nxt = cur - AW'(1);
            default:   nxt = cur + ext;
        endcase
    end

endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl (
    input  logic fire,
    input  logic irq_en,
    input  logic irq_sel,
    input  logic ring_mode,
    input  logic last_frame,
    input  logic last_blk,
    input  logic half,
    output logic irq
);
    logic qualify;

    always_comb begin
        if (ring_mode)
            qualify = irq_sel ? (last_frame | half) : last_frame;
        else
            qualify = irq_sel ? last_frame : last_blk;
        irq = fire & irq_en & qualify;
    end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int unsigned AW  = 16,
    parameter int unsigned CW  = 16,
    parameter int unsigned NEV = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    src_start,
    input  logic [AW-1:0]    dst_start,
    input  logic [1:0]       src_step,
    input  logic [1:0]       dst_step,
    input  logic [15:0]      elem_idx,
    input  logic [15:0]      frame_idx,
    input  logic [CW-1:0]    elem_cnt,
    input  logic [CW-1:0]    frame_cnt,
    input  logic             ring_mode,
    input  logic             irq_en,
    input  logic             irq_sel,
    input  logic [3:0]       sync_code,
    input  logic [NEV-1:0]   sync_ev,
    input  logic             xfer_done,
    output logic [AW-1:0]    src_addr,
    output logic [AW-1:0]    dst_addr,
    output logic             xfer_req,
    output logic             active,
    output logic             block_done,
    output logic             irq,
    output logic             overrun
);
    localparam int unsigned NSIDE = 2;

    seq_state_t    state_q, state_d;
    logic [CW-1:0] ecnt_q, fcnt_q;
    logic [CW-1:0] half_mark;
    logic          free_run, pending, consume, load;
    logic          fire, last_frame, last_blk, half;

    logic [AW-1:0] cur_a [NSIDE];
    logic [AW-1:0] nxt_a [NSIDE];
    logic [1:0]    sel_a [NSIDE];
    logic [AW-1:0] start_a [NSIDE];
    logic [AW-1:0] addr_q [NSIDE];

    assign free_run   = (sync_code == 4'b0000);
    assign load       = (state_q == ST_IDLE) && start;
    assign consume    = (state_q == ST_WAIT_EV) && !free_run && pending;
    assign fire       = (state_q == ST_REQ) && xfer_done;
    assign last_frame = (ecnt_q == CW'(1));
    assign last_blk   = last_frame && (fcnt_q == CW'(1)) && !ring_mode;
    assign half_mark  = elem_cnt - (elem_cnt >> 1) + CW'(1);
    assign half       = ring_mode && (ecnt_q == half_mark);

    assign sel_a[0]   = src_step;
    assign sel_a[1]   = dst_step;
    assign start_a[0] = src_start;
    assign start_a[1] = dst_start;

    dma_sync_sel #(.NEV(NEV)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .code    (sync_code),
        .ev      (sync_ev),
        .clr     (load),
        .consume (consume),
        .pending (pending),
        .overrun (overrun)
    );

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        assign cur_a[g] = addr_q[g];

        dma_addr_step #(.AW(AW)) step_i (
            .cur       (cur_a[g]),
            .sel       (sel_a[g]),
            .elem_idx  (elem_idx),
            .frame_idx (frame_idx),
            .last      (last_frame),
            .nxt       (nxt_a[g])
        );

        always_ff @(posedge clk) begin
            if (!rst_n)
                addr_q[g] <= '0;
            else if (load)
                addr_q[g] <= start_a[g];
            else if (fire)
                addr_q[g] <= nxt_a[g];
        end
    end

    dma_irq_ctl irq_i (
        .fire       (fire),
        .irq_en     (irq_en),
        .irq_sel    (irq_sel),
        .ring_mode  (ring_mode),
        .last_frame (last_frame),
        .last_blk   (last_blk),
        .half       (half),
        .irq        (irq)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_WAIT_EV;
            ST_WAIT_EV: if (free_run || pending) state_d = ST_REQ;
            ST_REQ:     if (xfer_done) state_d = last_blk ? ST_IDLE : ST_WAIT_EV;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Element and frame counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecnt_q <= '0;
            fcnt_q <= '0;
        end else if (load) begin
            ecnt_q <= elem_cnt;
            fcnt_q <= frame_cnt;
        end else if (fire) begin
            if (last_frame) begin
                ecnt_q <= elem_cnt;
                if (!ring_mode) fcnt_q <= fcnt_q - CW'(1);
            end else begin
                ecnt_q <= ecnt_q - CW'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        xfer_req   = (state_q == ST_REQ);
        active     = (state_q != ST_IDLE);
        block_done = fire && last_blk;
        src_addr   = addr_q[0];
        dst_addr   = addr_q[1];
    end

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          ring_mode,
    input logic          irq_en,
    input logic          xfer_done,
    input logic [AW-1:0] src_addr,
    input logic [AW-1:0] dst_addr,
    input logic          xfer_req,
    input logic          active,
    input logic          block_done,
    input logic          irq,
    input logic          overrun
);
    a_r14_req_active: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> active);

    a_r14_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> ($stable(src_addr) && $stable(dst_addr) && xfer_req));

    a_r14_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (xfer_done && xfer_req));

    a_r6_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |=> !active);

    a_r7_block_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (block_done && irq_en) |-> irq);

    a_r9_ring_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        ring_mode |-> !block_done);

    a_r13_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !start) |=> overrun);

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ring_mode  (ring_mode),
    .irq_en     (irq_en),
    .xfer_done  (xfer_done),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .xfer_req   (xfer_req),
    .active     (active),
    .block_done (block_done),
    .irq        (irq),
    .overrun    (overrun)
);

// File: tb/dma_chan_seq_tb_top.sv
`timescale 1ns/1ps
module dma_chan_seq_tb_top;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int NEV = 7;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [AW-1:0]  src_start = '0, dst_start = '0;
    logic [1:0]     src_step = 2'b00, dst_step = 2'b00;
    logic [15:0]    elem_idx = '0, frame_idx = '0;
    logic [CW-1:0]  elem_cnt = CW'(1), frame_cnt = CW'(1);
    logic           ring_mode = 1'b0, irq_en = 1'b0, irq_sel = 1'b0;
    logic [3:0]     sync_code = 4'b0000;
    logic [NEV-1:0] sync_ev = '0;
    logic           xfer_done = 1'b0;
    logic [AW-1:0]  src_addr, dst_addr;
    logic           xfer_req, active, block_done, irq, overrun;

    dma_chan_seq #(.AW(AW), .CW(CW), .NEV(NEV)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_start(src_start), .dst_start(dst_start),
        .src_step(src_step), .dst_step(dst_step),
        .elem_idx(elem_idx), .frame_idx(frame_idx),
        .elem_cnt(elem_cnt), .frame_cnt(frame_cnt),
        .ring_mode(ring_mode), .irq_en(irq_en), .irq_sel(irq_sel),
        .sync_code(sync_code), .sync_ev(sync_ev), .xfer_done(xfer_done),
        .src_addr(src_addr), .dst_addr(dst_addr), .xfer_req(xfer_req),
        .active(active), .block_done(block_done), .irq(irq), .overrun(overrun)
    );

    typedef struct {
        logic [AW-1:0] s;
        logic [AW-1:0] d;
        bit            irq;
        bit            bd;
    } exp_t;

    exp_t          exp_q[$];
    int            n_chk = 0;
    int            n_fail = 0;
    int            n_resp = 0;
    logic [AW-1:0] fin_s, fin_d;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] step(input logic [AW-1:0] cur, input logic [1:0] sel, input bit last);
        logic [15:0] idx;
        idx = last ? frame_idx : elem_idx;
        case (sel)
            2'b00:   return cur;
            2'b01:   return cur + 1'b1;
            2'b10:   return cur - 1'b1;
            default: return cur + AW'($signed(idx));
        endcase
    endfunction

    // Driver: compute the expected transfer list and push it to the scoreboard
    task automatic plan_run(input int e, input int f, input int n);
        logic [AW-1:0] s, d;
        s = src_start;
        d = dst_start;
        for (int k = 0; k < n; k++) begin
            exp_t it;
            int pos;
            int frm;
            bit last;
            pos  = (k % e) + 1;
            frm  = k / e;
            last = (pos == e);
            it.s = s;
            it.d = d;
            it.bd = !ring_mode && last && (frm == f - 1);
            if (!irq_en)        it.irq = 1'b0;
            else if (ring_mode) it.irq = irq_sel ? (last || pos == e / 2) : last;
            else                it.irq = irq_sel ? last : it.bd;
            exp_q.push_back(it);
            s = step(s, src_step, last);
            d = step(d, dst_step, last);
        end
        fin_s = s;
        fin_d = d;
    endtask

    // Monitor / responder: answers requests and compares against the queue
    initial begin
        forever begin
            @(negedge clk);
            if (xfer_done) begin
                xfer_done = 1'b0;
            end else if (xfer_req && exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                check("R2/R3/R4 src_addr", 32'(src_addr), 32'(it.s));
                check("R2/R3/R4 dst_addr", 32'(dst_addr), 32'(it.d));
                xfer_done = 1'b1;
                #1;
                check("R6/R7/R8/R9/R10 irq", 32'(irq), 32'(it.irq));
                check("R5 block_done", 32'(block_done), 32'(it.bd));
                n_resp++;
            end
        end
    end

    task automatic do_reset();
        exp_q.delete();
        rst_n = 1'b0;
        sync_ev = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while (exp_q.size() > 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_ev(input int b);
        @(negedge clk);
        sync_ev[b] = 1'b1;
        @(negedge clk);
        sync_ev[b] = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 xfer_req", 32'(xfer_req), 0);
        check("R1 active", 32'(active), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 block_done", 32'(block_done), 0);
        check("R1 overrun", 32'(overrun), 0);
        check("R1 src_addr", 32'(src_addr), 0);
        check("R1 dst_addr", 32'(dst_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Multi-frame, per-frame interrupts, indexed source, wrapping destination
        src_start = 16'h0100; dst_start = 16'hFFFE;
        src_step = 2'b11; dst_step = 2'b01;
        elem_idx = 16'd4; frame_idx = 16'hFFFA;
        elem_cnt = 3; frame_cnt = 2;
        irq_en = 1'b1; irq_sel = 1'b1; ring_mode = 1'b0; sync_code = 4'b0000;
        plan_run(3, 2, 6);
        pulse_start();
        check("R2 active after start", 32'(active), 1);
        check("R11 no request one cycle after start", 32'(xfer_req), 0);
        @(negedge clk);
        check("R11 request two cycles after start", 32'(xfer_req), 1);
        drain();
        check("R11 free-running count", 32'(n_resp), 6);
        check("R5 active cleared", 32'(active), 0);
        check("R3 final src", 32'(src_addr), 32'(fin_s));
        check("R3 final dst wrap", 32'(dst_addr), 32'(fin_d));

        // Multi-frame, block-only interrupt, decrement / hold
        src_step = 2'b10; dst_step = 2'b00; irq_sel = 1'b0;
        elem_cnt = 3; frame_cnt = 2;
        plan_run(3, 2, 6);
        pulse_start();
        drain();
        check("R7 queue drained", 32'(exp_q.size()), 0);
        check("R5 idle after block", 32'(active), 0);

        // Interrupts disabled, both sides indexed
        irq_en = 1'b0; src_step = 2'b11; dst_step = 2'b11;
        elem_idx = 16'hFFFF; frame_idx = 16'h0010;
        elem_cnt = 2; frame_cnt = 3;
        plan_run(2, 3, 6);
        pulse_start();
        drain();
        check("R6 queue drained", 32'(exp_q.size()), 0);

        // Single frame: frame index on the last transfer
        irq_en = 1'b1; irq_sel = 1'b1;
        src_start = 16'h2000; dst_start = 16'h3000;
        elem_idx = 16'd2; frame_idx = 16'h8000;
        elem_cnt = 4; frame_cnt = 1;
        plan_run(4, 1, 4);
        pulse_start();
        drain();
        check("R4 single-frame final src", 32'(src_addr), 32'(fin_s));
        check("R4 single-frame final dst", 32'(dst_addr), 32'(fin_d));

        // Ring mode, half and full interrupts
        do_reset();
        ring_mode = 1'b1; irq_en = 1'b1; irq_sel = 1'b1;
        src_step = 2'b11; dst_step = 2'b01;
        elem_idx = 16'd1; frame_idx = 16'hFFFB;
        elem_cnt = 6; frame_cnt = 1;
        plan_run(6, 1, 12);
        pulse_start();
        drain();
        check("R10 ring still active", 32'(active), 1);
        check("R10 ring request pending", 32'(xfer_req), 1);

        // Ring mode, full-only interrupt
        do_reset();
        irq_sel = 1'b0; elem_cnt = 4;
        plan_run(4, 1, 8);
        pulse_start();
        drain();
        check("R9 ring still active", 32'(active), 1);

        // Synchronized pacing on bit3 (code 0110)
        do_reset();
        ring_mode = 1'b0; irq_en = 1'b1; irq_sel = 1'b1;
        sync_code = 4'b0110; elem_cnt = 3; frame_cnt = 1;
        src_step = 2'b01; dst_step = 2'b01;
        plan_run(3, 1, 3);
        pulse_start();
        repeat (4) @(negedge clk);
        check("R12 no transfer before event", 32'(xfer_req), 0);
        base = n_resp;
        pulse_ev(0);
        pulse_ev(6);
        check("R12 unselected lines ignored", 32'(n_resp - base), 0);
        pulse_ev(3);
        check("R12 one transfer per edge (1)", 32'(n_resp - base), 1);
        pulse_ev(3);
        check("R12 one transfer per edge (2)", 32'(n_resp - base), 2);
        pulse_ev(3);
        check("R12 one transfer per edge (3)", 32'(n_resp - base), 3);
        check("R5 synced block finished", 32'(active), 0);

        // Reserved code never triggers
        do_reset();
        sync_code = 4'b0011; elem_cnt = 2; frame_cnt = 1;
        plan_run(2, 1, 2);
        pulse_start();
        base = n_resp;
        for (int b = 0; b < NEV; b++) pulse_ev(b);
        check("R12 reserved code no request", 32'(xfer_req), 0);
        check("R12 reserved code no transfer", 32'(n_resp - base), 0);

        // Overrun: edges stacked during an unanswered request (code 1101 -> bit4)
        do_reset();
        sync_code = 4'b1101;
        pulse_start();
        pulse_ev(4);
        check("R13 request after edge", 32'(xfer_req), 1);
        pulse_ev(4);
        check("R13 one pending edge no overrun", 32'(overrun), 0);
        pulse_ev(4);
        check("R13 overrun on second pending edge", 32'(overrun), 1);
        check("R14 request still held", 32'(xfer_req), 1);
        repeat (4) @(negedge clk);
        check("R13 overrun sticky", 32'(overrun), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule